// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is the register-mapped core of an SMBus master. Software fills in a target address, a command byte and two data bytes through a simple synchronous register port. It then writes a control byte that carries a protocol code and a start bit. The controller breaks the selected transaction into byte-sized requests for a separate bit-level engine, which does the wire-level signalling. It collects the engine's responses and reports the result through a status byte whose error and done flags software clears by writing 1.

Four protocols are supported: quick, byte, byte-data and word-data, each in read or write form. The direction is taken from bit 0 of the address register. Data read from the target lands in the data registers, with the low byte in data0 and the high byte in data1. A kill bit in the control byte abandons a transaction in flight. A kill signals the engine to release the bus and marks the transaction as failed.

The engine request channel is valid/ready. The controller raises `eng_req_valid` and holds every request field stable until `eng_req_ready` is seen high at a clock edge. The one exception is a kill, which withdraws the request. The engine answers each accepted request with a single-cycle `eng_rsp_valid` pulse, no earlier than the cycle after acceptance. The controller always accepts a response while it is waiting for one and ignores `eng_rsp_valid` at any other time. After an error response the engine is expected to release the bus by itself.

Top module: `smbus_host_ctrl`

## Requirements
- R1: After reset, status, control, command, address, data0 and data1 all read 0, and no engine request is pending.
- R2: The command register (word index 3), address register (index 4), data0 (index 5) and data1 (index 6) read back what was last written while the controller was idle.
- R3: Writing the control register (index 2) with bit 6 set, bit 1 clear and a supported code in bits [4:2] starts a transaction. From the next cycle the busy flag (status bit 0) reads 1. Bit 6 always reads back 0, while bits [4:2] read back the code.
- R4: Code 0 (quick) sends the address byte unchanged with start and stop. Code 1 (byte) sends the address with the write bit and then the command with stop, or, for a read, the address with the read bit and then one read byte with stop, which goes to data0.
- R5: Code 2 (byte-data) and code 3 (word-data) send the address with the write bit and then the command. A write then sends data0 (and data1 for word). A read issues a repeated start with the address and the read bit, then reads into data0 (and data1 for word). The last byte carries stop. Read requests carry a data byte of 0.
- R6: When the final byte completes with acknowledge, busy clears and the done flag (status bit 1) sets at the same clock edge.
- R7: A written byte answered without acknowledge sets the device-error flag (status bit 2), clears busy, issues no further requests and leaves the done flag clear.
- R8: A response reporting lost arbitration sets the bus-error flag (status bit 3) and clears busy.
- R9: Writing the status register clears each of bits 4..1 that is written as 1 and leaves bits written as 0 unchanged. Busy cannot be written.
- R10: While busy, a start is ignored, and writes to control (other than kill), command, address and data registers are ignored.
- R11: A control write with bit 1 (kill) set always sets the failed flag (status bit 4) and never starts a transaction. When busy, it clears busy and withdraws any request at the next edge, and `eng_abort` pulses for one cycle.
- R12: A start with an unsupported code (4..7, including the block code 0x14) sets the failed flag and issues no request.
- R13: While `eng_req_valid` is high and `eng_req_ready` is low, the request stays valid with unchanged fields unless a kill occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the register at reg_idx |
| eng_req_valid | output | 1 | Engine request valid |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_data | output | 8 | Byte to send (0 for reads) |
| eng_req_read | output | 1 | Request reads a byte from the target |
| eng_req_start | output | 1 | Issue start or repeated start before this byte |
| eng_req_stop | output | 1 | Issue stop after this byte (and NACK a read byte) |
| eng_rsp_valid | input | 1 | One-cycle response pulse |
| eng_rsp_data | input | 8 | Byte read from the target |
| eng_rsp_ack | input | 1 | Target acknowledged the written byte |
| eng_rsp_arb_lost | input | 1 | Arbitration was lost on this byte |
| eng_abort | output | 1 | One-cycle pulse telling the engine to release the bus |

## Verification
The bench builds the controller with its default 8-bit data width and 4-bit register index. These are the only values that match the SMBus byte framing and the word map. With them every protocol code, both directions, the unsupported codes and the full flag byte can all be reached from the register port. The engine model in the bench can hold ready low indefinitely or stall it one cycle in three. This brings request back-pressure, kills during a pending request and writes made while busy all within reach.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int STEP_W = 3;

  localparam logic [3:0] IDX_STAT = 4'd0;
  localparam logic [3:0] IDX_CTRL = 4'd2;
  localparam logic [3:0] IDX_CMD  = 4'd3;
  localparam logic [3:0] IDX_ADDR = 4'd4;
  localparam logic [3:0] IDX_D0   = 4'd5;
  localparam logic [3:0] IDX_D1   = 4'd6;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;

  typedef enum logic [2:0] {
    SRC_ADDR_RAW, SRC_ADDR_W, SRC_ADDR_R, SRC_CMD,
    SRC_D0, SRC_D1, SRC_RD0, SRC_RD1
  } src_e;

  typedef struct packed {
    logic start;
    logic stop;
    src_e src;
  } step_t;

  function automatic step_t mk_step(logic s, logic p, src_e c);
    step_t r;
    r.start = s;
    r.stop  = p;
    r.src   = c;
    return r;
  endfunction
endpackage

// File: rtl/smbh_step_table.sv
module smbh_step_table
  import smbh_pkg::*;
#(
  parameter int SW = STEP_W
) (
  input  logic [2:0]    proto,
  input  logic          rnw,
  input  logic [SW-1:0] idx,
  output step_t         step
);
  always_comb begin
    step = mk_step(1'b1, 1'b1, SRC_ADDR_RAW);
    case (proto)
      PR_BYTE: begin
        if (idx == '0) step = mk_step(1'b1, 1'b0, rnw ? SRC_ADDR_R : SRC_ADDR_W);
        else           step = mk_step(1'b0, 1'b1, rnw ? SRC_RD0 : SRC_CMD);
      end
      PR_BDATA, PR_WORD: begin
        case (idx)
          SW'(0): step = mk_step(1'b1, 1'b0, SRC_ADDR_W);
          SW'(1): step = mk_step(1'b0, 1'b0, SRC_CMD);
          SW'(2): begin
            if (rnw)                 step = mk_step(1'b1, 1'b0, SRC_ADDR_R);
            else if (proto == PR_WORD) step = mk_step(1'b0, 1'b0, SRC_D0);
            else                     step = mk_step(1'b0, 1'b1, SRC_D0);
          end
          SW'(3): begin
            if (!rnw)                step = mk_step(1'b0, 1'b1, SRC_D1);
            else if (proto == PR_WORD) step = mk_step(1'b0, 1'b0, SRC_RD0);
            else                     step = mk_step(1'b0, 1'b1, SRC_RD0);
          end
          default: step = mk_step(1'b0, 1'b1, SRC_RD1);
        endcase
      end
      default: step = mk_step(1'b1, 1'b1, SRC_ADDR_RAW);
    endcase
  end
endmodule

// File: rtl/smbh_xfer.sv
module smbh_xfer
  import smbh_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2:0]    go_code,
  input  logic          kill,
  input  logic [DW-1:0] addr_q,
  input  logic [DW-1:0] cmd_q,
  input  logic [DW-1:0] d0_q,
  input  logic [DW-1:0] d1_q,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_data,
  output logic          req_read,
  output logic          req_start,
  output logic          req_stop,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          rsp_ack,
  input  logic          rsp_arb,
  output logic          busy,
  output logic          end_ok,
  output logic          end_dev,
  output logic          end_bus,
  output logic          ld0,
  output logic          ld1,
  output logic [DW-1:0] ld_data,
  output logic          abort
);
  typedef enum logic [1:0] {X_IDLE, X_ISSUE, X_WAIT} xst_e;

  xst_e              state_q;
  logic [2:0]        proto_q;
  logic [STEP_W-1:0] idx_q;
  step_t             cur;
  logic              live, ok_step;

  smbh_step_table #(.SW(STEP_W)) u_tbl (
    .proto(proto_q), .rnw(addr_q[0]), .idx(idx_q), .step(cur)
  );

  always_comb begin
    case (cur.src)
      SRC_ADDR_RAW: req_data = addr_q;
      SRC_ADDR_W:   req_data = {addr_q[DW-1:1], 1'b0};
      SRC_ADDR_R:   req_data = {addr_q[DW-1:1], 1'b1};
      SRC_CMD:      req_data = cmd_q;
      SRC_D0:       req_data = d0_q;
      SRC_D1:       req_data = d1_q;
      default:      req_data = '0;
    endcase
  end

  assign req_read  = (cur.src == SRC_RD0) || (cur.src == SRC_RD1);
  assign req_start = cur.start;
  assign req_stop  = cur.stop;
  assign req_valid = (state_q == X_ISSUE);
  assign busy      = (state_q != X_IDLE);

  assign live    = (state_q == X_WAIT) && rsp_valid && !kill;
  assign end_bus = live && rsp_arb;
  assign end_dev = live && !rsp_arb && !req_read && !rsp_ack;
  assign ok_step = live && !rsp_arb && (req_read || rsp_ack);
  assign end_ok  = ok_step && cur.stop;
  assign ld0     = ok_step && (cur.src == SRC_RD0);
  assign ld1     = ok_step && (cur.src == SRC_RD1);
  assign ld_data = rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= X_IDLE;
      proto_q <= '0;
      idx_q   <= '0;
      abort   <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (kill && state_q != X_IDLE) begin
        state_q <= X_IDLE;
        abort   <= 1'b1;
      end else begin
        case (state_q)
          X_IDLE: if (go) begin
            proto_q <= go_code;
            idx_q   <= '0;
            state_q <= X_ISSUE;
          end
          X_ISSUE: if (req_ready) state_q <= X_WAIT;
          X_WAIT: begin
            if (end_bus || end_dev || end_ok) begin
              state_q <= X_IDLE;
            end else if (ok_step) begin
              idx_q   <= idx_q + 1'b1;
              state_q <= X_ISSUE;
            end
          end
          default: state_q <= X_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
  import smbh_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             eng_req_valid,
  input  logic             eng_req_ready,
  output logic [DW-1:0]    eng_req_data,
  output logic             eng_req_read,
  output logic             eng_req_start,
  output logic             eng_req_stop,
  input  logic             eng_rsp_valid,
  input  logic [DW-1:0]    eng_rsp_data,
  input  logic             eng_rsp_ack,
  input  logic             eng_rsp_arb_lost,
  output logic             eng_abort
);
  localparam int NFLAG = 4;

  logic [DW-1:0]    cmd_q, addr_q, d0_q, d1_q;
  logic [2:0]       proto_q;
  logic [NFLAG-1:0] flag_q;
  logic             busy_w, end_ok, end_dev, end_bus, ld0, ld1;
  logic [DW-1:0]    ld_data;
  logic             ctrl_wr, kill_req, start_req, go, bad_code;
  logic [2:0]       code;
  logic [NFLAG-1:0] clr, set;

  assign ctrl_wr   = reg_wr && (reg_idx == IDX_W'(IDX_CTRL));
  assign code      = reg_wdata[4:2];
  assign kill_req  = ctrl_wr && reg_wdata[1];
  assign start_req = ctrl_wr && !reg_wdata[1] && reg_wdata[6] && !busy_w;
  assign go        = start_req && (code < 3'd4);
  assign bad_code  = start_req && (code >= 3'd4);

  smbh_xfer #(.DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(go), .go_code(code), .kill(kill_req),
    .addr_q(addr_q), .cmd_q(cmd_q), .d0_q(d0_q), .d1_q(d1_q),
    .req_valid(eng_req_valid), .req_ready(eng_req_ready), .req_data(eng_req_data),
    .req_read(eng_req_read), .req_start(eng_req_start), .req_stop(eng_req_stop),
    .rsp_valid(eng_rsp_valid), .rsp_data(eng_rsp_data), .rsp_ack(eng_rsp_ack),
    .rsp_arb(eng_rsp_arb_lost), .busy(busy_w), .end_ok(end_ok), .end_dev(end_dev),
    .end_bus(end_bus), .ld0(ld0), .ld1(ld1), .ld_data(ld_data), .abort(eng_abort)
  );

  // flag order: {failed, bus error, device error, done} = status bits 4..1
  assign clr = (reg_wr && reg_idx == IDX_W'(IDX_STAT)) ? reg_wdata[4:1] : '0;
  assign set = {kill_req || bad_code, end_bus, end_dev, end_ok};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      proto_q <= '0;
      flag_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | set;
      if (reg_wr && !busy_w) begin
        case (reg_idx)
          IDX_W'(IDX_CMD):  cmd_q  <= reg_wdata;
          IDX_W'(IDX_ADDR): addr_q <= reg_wdata;
          IDX_W'(IDX_D0):   d0_q   <= reg_wdata;
          IDX_W'(IDX_D1):   d1_q   <= reg_wdata;
          IDX_W'(IDX_CTRL): if (!reg_wdata[1]) proto_q <= code;
          default: ;
        endcase
      end
      if (ld0) d0_q <= ld_data;
      if (ld1) d1_q <= ld_data;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_W'(IDX_STAT): reg_rdata = DW'({flag_q, busy_w});
      IDX_W'(IDX_CTRL): reg_rdata = DW'({proto_q, 2'b00});
      IDX_W'(IDX_CMD):  reg_rdata = cmd_q;
      IDX_W'(IDX_ADDR): reg_rdata = addr_q;
      IDX_W'(IDX_D0):   reg_rdata = d0_q;
      IDX_W'(IDX_D1):   reg_rdata = d1_q;
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smbh_checker.sv
module smbh_checker #(
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [IDX_W-1:0] reg_idx,
  input logic [DW-1:0]    reg_wdata,
  input logic             busy,
  input logic [3:0]       flags,
  input logic             req_valid,
  input logic             req_ready,
  input logic [DW-1:0]    req_data,
  input logic             req_read,
  input logic             req_start,
  input logic             req_stop,
  input logic             abort
);
  logic start_ok, kill_wr;
  assign start_ok = reg_wr && reg_idx == IDX_W'(2) && reg_wdata[6] && !reg_wdata[1]
                    && reg_wdata[4:2] < 3'd4;
  assign kill_wr  = reg_wr && reg_idx == IDX_W'(2) && reg_wdata[1];

  // R3: an accepted start makes the controller busy
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && !busy |=> busy);

  // R6, R7, R8, R11: busy never drops without a reason in the flags
  assert_end_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (flags != 4'b0000));

  // R7: a device error ending a transaction does not also raise done
  assert_dev_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $rose(flags[1]) |-> !$rose(flags[0]));

  // R11: abort pulse comes with idle and failed
  assert_kill_fail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !busy && flags[3] && !req_valid);

  // R11: a kill never starts anything
  assert_kill_nostart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wr && !busy |=> !busy);

  // R12: no request while idle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R13: request held under back-pressure
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !kill_wr |=> req_valid && $stable(req_data)
      && $stable(req_read) && $stable(req_start) && $stable(req_stop));
endmodule

bind smbus_host_ctrl smbh_checker #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .busy(busy_w), .flags(flag_q), .req_valid(eng_req_valid), .req_ready(eng_req_ready),
  .req_data(eng_req_data), .req_read(eng_req_read), .req_start(eng_req_start),
  .req_stop(eng_req_stop), .abort(eng_abort)
);

// File: tb/smbus_host_ctrl_tb.sv
module smbus_host_ctrl_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       eng_req_valid, eng_req_read, eng_req_start, eng_req_stop, eng_abort;
  logic [7:0] eng_req_data;
  logic       eng_req_ready = 1'b0;
  logic       eng_rsp_valid = 1'b0;
  logic [7:0] eng_rsp_data = '0;
  logic       eng_rsp_ack = 1'b0;
  logic       eng_rsp_arb_lost = 1'b0;

  smbus_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_req_data(eng_req_data), .eng_req_read(eng_req_read), .eng_req_start(eng_req_start),
    .eng_req_stop(eng_req_stop), .eng_rsp_valid(eng_rsp_valid), .eng_rsp_data(eng_rsp_data),
    .eng_rsp_ack(eng_rsp_ack), .eng_rsp_arb_lost(eng_rsp_arb_lost), .eng_abort(eng_abort)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  bit         m_busy, m_pend, m_wait;
  logic [7:0] m_addr, m_cmd, m_d0, m_d1;
  logic [3:0] m_flags;
  int         m_step, m_n;
  logic       e_start[8], e_stop[8], e_read[8], e_tgt[8];
  logic [7:0] e_data[8];
  logic       p_ack[8], p_arb[8];
  logic [7:0] p_rd[8];
  int         ready_mode = 0;
  int         tick = 0;
  logic       pv, prdy, prsp, pstart, pstop, pread;
  logic [7:0] pdata;

  task automatic push(logic s, logic p, logic r, logic t, logic [7:0] d);
    e_start[m_n] = s; e_stop[m_n] = p; e_read[m_n] = r; e_tgt[m_n] = t; e_data[m_n] = d;
    m_n++;
  endtask

  task automatic build(logic [2:0] c);
    logic [7:0] aw, ar;
    aw = {m_addr[7:1], 1'b0};
    ar = {m_addr[7:1], 1'b1};
    m_n = 0;
    if (c == 0) push(1, 1, 0, 0, m_addr);
    else if (c == 1) begin
      if (m_addr[0]) begin push(1, 0, 0, 0, ar); push(0, 1, 1, 0, 8'h00); end
      else begin push(1, 0, 0, 0, aw); push(0, 1, 0, 0, m_cmd); end
    end else begin
      push(1, 0, 0, 0, aw);
      push(0, 0, 0, 0, m_cmd);
      if (m_addr[0]) begin
        push(1, 0, 0, 0, ar);
        push(0, c == 2, 1, 0, 8'h00);
        if (c == 3) push(0, 1, 1, 1, 8'h00);
      end else begin
        push(0, c == 2, 0, 0, m_d0);
        if (c == 3) push(0, 1, 0, 0, m_d1);
      end
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    tick++;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_wait = 0; m_flags = 0; m_step = 0; m_n = 0;
      m_addr = 0; m_cmd = 0; m_d0 = 0; m_d1 = 0;
      eng_req_ready = 0; eng_rsp_valid = 0;
      pv = 0; prdy = 0; prsp = 0; pstart = 0; pstop = 0; pread = 0; pdata = 0;
    end else begin
      automatic bit busy_b = m_busy;
      automatic bit hs = pv && prdy;
      automatic bit ex_abort = 0;
      if (reg_wr) begin
        case (reg_idx)
          4'd0: m_flags = m_flags & ~reg_wdata[4:1];
          4'd2: begin
            if (reg_wdata[1]) begin
              m_flags[3] = 1;
              if (busy_b) begin ex_abort = 1; m_busy = 0; m_pend = 0; m_wait = 0; end
            end else if (!busy_b && reg_wdata[6]) begin
              if (reg_wdata[4:2] < 3'd4) begin
                build(reg_wdata[4:2]); m_busy = 1; m_pend = 1; m_step = 0;
              end else m_flags[3] = 1;
            end
          end
          4'd3: if (!busy_b) m_cmd = reg_wdata;
          4'd4: if (!busy_b) m_addr = reg_wdata;
          4'd5: if (!busy_b) m_d0 = reg_wdata;
          4'd6: if (!busy_b) m_d1 = reg_wdata;
          default: ;
        endcase
      end
      if (hs && !ex_abort) begin
        chk(pdata == e_data[m_step], "R4/R5", "request byte", pdata, e_data[m_step]);
        chk({pstart, pstop, pread} == {e_start[m_step], e_stop[m_step], e_read[m_step]},
            "R4/R5", "request flags", {pstart, pstop, pread},
            {e_start[m_step], e_stop[m_step], e_read[m_step]});
        m_pend = 0; m_wait = 1;
      end else if (prsp && m_wait && !ex_abort) begin
        m_wait = 0;
        if (p_arb[m_step]) begin m_flags[2] = 1; m_busy = 0; end
        else if (!e_read[m_step] && !p_ack[m_step]) begin m_flags[1] = 1; m_busy = 0; end
        else begin
          if (e_read[m_step]) begin
            if (e_tgt[m_step]) m_d1 = p_rd[m_step]; else m_d0 = p_rd[m_step];
          end
          if (e_stop[m_step]) begin m_flags[0] = 1; m_busy = 0; end
          else begin m_pend = 1; m_step++; end
        end
      end
      chk(eng_req_valid == m_pend, "R4", "req_valid per cycle", eng_req_valid, m_pend);
      chk(eng_abort == ex_abort, "R11", "abort pulse", eng_abort, ex_abort);
      if (pv && !prdy && eng_req_valid)
        chk(eng_req_data == pdata && {eng_req_start, eng_req_stop, eng_req_read} ==
            {pstart, pstop, pread}, "R13", "held request", eng_req_data, pdata);
      if (hs && !ex_abort) begin
        eng_rsp_valid = 1; eng_rsp_data = p_rd[m_step];
        eng_rsp_ack = p_ack[m_step]; eng_rsp_arb_lost = p_arb[m_step];
      end else begin
        eng_rsp_valid = 0; eng_rsp_data = 8'hEE; eng_rsp_ack = 0; eng_rsp_arb_lost = 0;
      end
      if (ready_mode == 0) eng_req_ready = 1;
      else if (ready_mode == 1) eng_req_ready = (tick % 3 != 0);
      else eng_req_ready = 0;
      pv = eng_req_valid; prdy = eng_req_ready; prsp = eng_rsp_valid;
      pdata = eng_req_data; pstart = eng_req_start; pstop = eng_req_stop; pread = eng_req_read;
    end
  end

  task automatic wr(logic [3:0] i, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] i, logic [7:0] exp, string req);
    @(negedge clk);
    reg_idx = i;
    #1;
    chk(reg_rdata == exp, req, $sformatf("read idx %0d", i), reg_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && m_busy; k++) @(negedge clk);
  endtask

  task automatic plan_clear();
    for (int k = 0; k < 8; k++) begin p_ack[k] = 1; p_arb[k] = 0; p_rd[k] = 8'h00; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    plan_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(0, 8'h00, "R1"); rd(2, 8'h00, "R1"); rd(3, 8'h00, "R1");
    rd(4, 8'h00, "R1"); rd(5, 8'h00, "R1"); rd(6, 8'h00, "R1");
    // R2 readback
    wr(3, 8'h5A); wr(4, 8'hA0); wr(5, 8'h12); wr(6, 8'h34);
    rd(3, 8'h5A, "R2"); rd(4, 8'hA0, "R2"); rd(5, 8'h12, "R2"); rd(6, 8'h34, "R2");
    // R3 R4 R6 quick write
    wr(2, 8'h40);
    rd(0, 8'h01, "R3"); rd(2, 8'h00, "R3");
    wait_idle();
    rd(0, 8'h02, "R6");
    // R9 write-one-to-clear
    wr(0, 8'h00); rd(0, 8'h02, "R9");
    wr(0, 8'hFF); rd(0, 8'h00, "R9");
    // R4 byte read with stalls, R13
    ready_mode = 1; plan_clear(); p_rd[1] = 8'hA5;
    wr(4, 8'hA1); wr(2, 8'h44);
    rd(2, 8'h04, "R3");
    wait_idle(); rd(5, 8'hA5, "R4"); rd(0, 8'h02, "R6");
    // R4 byte write
    wr(0, 8'h1E); wr(4, 8'h60); wr(3, 8'h77); wr(2, 8'h44); wait_idle();
    rd(0, 8'h02, "R4");
    // R5 byte-data read
    wr(0, 8'h1E); plan_clear(); p_rd[3] = 8'h3C;
    wr(4, 8'h61); wr(3, 8'h10); wr(2, 8'h48); wait_idle();
    rd(5, 8'h3C, "R5"); rd(0, 8'h02, "R5");
    // R5 word write
    wr(0, 8'h1E); wr(4, 8'h62); wr(5, 8'hC3); wr(6, 8'h96); wr(2, 8'h4C); wait_idle();
    rd(0, 8'h02, "R5");
    // R5 word read, low byte to data0
    wr(0, 8'h1E); plan_clear(); p_rd[3] = 8'h11; p_rd[4] = 8'h22; ready_mode = 0;
    wr(4, 8'h63); wr(2, 8'h4C); wait_idle();
    rd(5, 8'h11, "R5"); rd(6, 8'h22, "R5");
    // R7 NACK on command byte of word write
    wr(0, 8'h1E); plan_clear(); p_ack[1] = 0;
    wr(4, 8'h64); wr(2, 8'h4C); wait_idle();
    repeat (4) @(negedge clk);
    rd(0, 8'h04, "R7");
    // R8 arbitration lost on first byte
    wr(0, 8'h1E); plan_clear(); p_arb[0] = 1;
    wr(2, 8'h48); wait_idle();
    rd(0, 8'h08, "R8");
    // R10 writes while busy are ignored
    wr(0, 8'h1E); plan_clear(); ready_mode = 2;
    wr(4, 8'h30); wr(3, 8'h21); wr(5, 8'h42);
    wr(2, 8'h48);
    wr(3, 8'h99); wr(2, 8'h40); wr(4, 8'h00);
    ready_mode = 1; wait_idle();
    rd(3, 8'h21, "R10"); rd(4, 8'h30, "R10"); rd(2, 8'h08, "R10"); rd(0, 8'h02, "R10");
    // R11 kill while request is pending
    wr(0, 8'h1E); ready_mode = 2; plan_clear();
    wr(2, 8'h4C); repeat (3) @(negedge clk);
    wr(2, 8'h02);
    rd(0, 8'h10, "R11");
    // R11 kill together with start does not start
    wr(0, 8'h1E); ready_mode = 0;
    wr(2, 8'h42); repeat (3) @(negedge clk);
    rd(0, 8'h10, "R11");
    // R12 unsupported block code
    wr(0, 8'h1E); wr(2, 8'h54); repeat (3) @(negedge clk);
    rd(0, 8'h10, "R12");
    wr(0, 8'h1E); wr(2, 8'h5C); repeat (3) @(negedge clk);
    rd(0, 8'h10, "R12");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule